// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a timer counter advances. A 3-bit select field picks the source of a one-cycle count-enable strobe in the system clock domain. The timer can be halted, stepped on every clock, stepped once per 8, 64, 256 or 1024 clocks from a shared free-running prescaler, or stepped by edges on an external count pin. For the pin, the falling edge or the rising edge is chosen.

The external pin is taken in raw and passes through a two-flop synchronizer before edge detection. Nothing qualifies that input: whatever level reaches the pin is counted, including a level the chip drives onto the pin itself. Software can therefore step the timer by toggling its own output. A prescaler-clear input restarts the shared divider so that the next divided strobe lands one full period later. The counter, the compare logic and the register decoding all sit outside this block.

Top module: `tmr_clksel`

## Requirements
- R1: With select code 3'b000 the strobe `cen_o` stays low, whatever the pin does.
- R2: With select code 3'b001, `cen_o` is high on every clock that follows a clock edge at which the code was applied.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 give exactly one strobe per 8, 64, 256 and 1024 clocks respectively. No two strobes from these codes are ever adjacent, and the external pin has no effect on them.
- R4: Code 3'b110 gives one single-cycle strobe for each falling edge of `pin_i`. A pin change made between clock edges shows on `cen_o` after the third rising clock edge and is gone after the fourth.
- R5: Code 3'b111 gives one single-cycle strobe for each rising edge of `pin_i`, with the same latency as R4. Falling edges produce nothing in this mode.
- R6: While `psc_clr_i` is high, no divided strobe is produced. After it is released, the first strobe for divide-by-N appears after the Nth clock edge.
- R7: A new select code takes effect at the next clock edge and does not by itself cause a strobe. Switching between the two pin modes while the pin is steady produces no strobe.
- R8: Synchronous reset `rst_i` forces `cen_o` low, clears the prescaler and clears the synchronizer to a low pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System I/O clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 3 | Count source select code |
| pin_i | input | 1 | Raw external count pin, asynchronous |
| psc_clr_i | input | 1 | Prescaler clear, active high |
| cen_o | output | 1 | One-cycle count-enable strobe |

## Verification
The hardest state to reach from the ports is the exact phase of the shared prescaler. Its count cannot be seen directly, so every divided-ratio measurement starts by pulsing the prescaler clear. The bench then counts clock edges from the release, which makes the first-strobe position and the strobe counts per window deterministic. The pin path is driven between clock edges on a fixed toggle cadence, so the three-edge latency can be checked cycle by cycle. Mode switches are made with the pin held at a steady high, which exposes any strobe that the switch itself might cause.

// File: rtl/tmr_clksel_pkg.sv
package tmr_clksel_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } cs_code_e;

    // Prescaler width and the log2 of each tapped ratio (8, 64, 256, 1024)
    localparam int unsigned PSC_W    = 10;
    localparam int unsigned NUM_TAPS = 4;
    localparam int unsigned TAP_LOG [NUM_TAPS] = '{3, 6, 8, 10};
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
    import tmr_clksel_pkg::*;
#(
    parameter int unsigned W     = PSC_W,
    parameter int unsigned NTAPS = NUM_TAPS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    output logic [NTAPS-1:0] tap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A tap is live on the last count before its low bits wrap to zero
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign tap_o[g] = &st_q.cnt[TAP_LOG[g]-1:0];
    end

    // R6: a clear leaves the divider at zero on the next cycle
    a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (st_q.cnt == '0));

    // R3: without a clear the divider advances by exactly one
    a_r3_free_run: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && !$past(rst_i)) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge
    import tmr_clksel_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o =  st_q.sh[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.sh[STAGES-1] &  st_q.prev;

    // R4: the two edge indications never coincide
    a_r4_edges_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rise_o && fall_o));

    // R5: a rising indication lasts a single cycle
    a_r5_rise_single: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

    // R4: a falling indication lasts a single cycle
    a_r4_fall_single: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel
    import tmr_clksel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] sel_i,
    input  logic       pin_i,
    input  logic       psc_clr_i,
    output logic       cen_o
);

    typedef struct packed {
        logic cen;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_TAPS-1:0] tap;
    logic                pin_rise;
    logic                pin_fall;

    tcs_prescaler #(
        .W     (PSC_W),
        .NTAPS (NUM_TAPS)
    ) u_psc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (psc_clr_i),
        .tap_o (tap)
    );

    tcs_pin_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_comb begin
        st_d = st_q;
        unique case (cs_code_e'(sel_i))
            CS_STOP:     st_d.cen = 1'b0;
            CS_DIV1:     st_d.cen = 1'b1;
            CS_DIV8:     st_d.cen = tap[0];
            CS_DIV64:    st_d.cen = tap[1];
            CS_DIV256:   st_d.cen = tap[2];
            CS_DIV1024:  st_d.cen = tap[3];
            CS_EXT_FALL: st_d.cen = pin_fall;
            CS_EXT_RISE: st_d.cen = pin_rise;
            default:     st_d.cen = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cen_o = st_q.cen;

    // R1: the stop code yields no strobe on the following cycle
    a_r1_stop_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(sel_i) == 3'b000) |-> !cen_o);

    // R2: the undivided code yields a strobe on the following cycle
    a_r2_every_clock: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(sel_i) == 3'b001) |-> cen_o);

    // R3: divided strobes never sit on adjacent cycles
    a_r3_no_adjacent: assert property (@(posedge clk_i) disable iff (rst_i)
        (cen_o && !$past(rst_i) && $past(sel_i) >= 3'b010 && $past(sel_i) <= 3'b101
         && sel_i >= 3'b010 && sel_i <= 3'b101) |=> !cen_o);

    // R8: a reset cycle leaves the strobe low
    a_r8_reset_low: assert property (@(posedge clk_i)
        $past(rst_i) |-> !cen_o);

endmodule

// File: tb/tmr_clksel_tb.sv
module tmr_clksel_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;
    localparam int  NVEC       = 14;

    // Table: select code, window length, pin toggle period (0 = none), expected strobes
    localparam int V_SEL [NVEC] = '{0, 1, 2, 3, 3, 4, 5, 6, 7, 6, 7, 0, 2, 6};
    localparam int V_WIN [NVEC] = '{50, 20, 64, 64, 128, 256, 1024, 72, 72, 40, 40, 72, 72, 64};
    localparam int V_TOG [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 8, 8, 2, 2, 8, 8, 0};
    localparam int V_EXP [NVEC] = '{0, 20, 8, 1, 2, 1, 1, 4, 4, 8, 8, 0, 9, 0};
    localparam string V_REQ [NVEC] = '{"R1", "R2", "R3", "R3", "R3", "R3", "R3",
                                       "R4", "R5", "R4", "R5", "R1", "R3", "R4"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'b000;
    logic       pin = 1'b0;
    logic       pclr = 1'b0;
    logic       cen;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    tmr_clksel u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .sel_i     (sel),
        .pin_i     (pin),
        .psc_clr_i (pclr),
        .cen_o     (cen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        int cnt;
        int first;
        int seq;

        // R8: reset state
        @(negedge clk);
        repeat (3) tick();
        check("R8", int'(cen), 0, "strobe during reset");
        rst = 1'b0;
        tick();
        check("R8", int'(cen), 0, "strobe after reset release with stop code");

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            sel  = V_SEL[v][2:0];
            pclr = 1'b1;
            tick();
            pclr = 1'b0;
            cnt  = 0;
            for (int i = 1; i <= V_WIN[v]; i++) begin
                tick();
                if (cen) cnt++;
                if (V_TOG[v] != 0 && (i % V_TOG[v]) == 0 && i <= V_WIN[v] - 8)
                    pin = ~pin;
            end
            check(V_REQ[v], cnt, V_EXP[v], $sformatf("vector %0d strobe count", v));
        end

        // R6: held prescaler clear suppresses divided strobes, then full period
        sel = 3'b000;
        tick();
        sel  = 3'b010;
        pclr = 1'b1;
        cnt  = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cen) cnt++;
        end
        check("R6", cnt, 0, "strobes while prescaler clear held");
        pclr  = 1'b0;
        first = 0;
        for (int k = 1; k <= 20; k++) begin
            tick();
            if (cen && first == 0) first = k;
        end
        check("R6", first, 8, "first divide-by-8 strobe edge after release");

        // R5: exact latency of a rising pin edge
        sel = 3'b111;
        pin = 1'b0;
        repeat (6) tick();
        pin = 1'b1;
        seq = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            seq = (seq << 1) | int'(cen);
        end
        check("R5", seq, 4'b0010, "strobe pattern over four edges after rise");
        pin = 1'b0;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (cen) cnt++;
        end
        check("R5", cnt, 0, "falling edge ignored in rising mode");

        // R4: exact latency of a falling pin edge
        sel = 3'b110;
        pin = 1'b1;
        repeat (6) tick();
        pin = 1'b0;
        seq = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            seq = (seq << 1) | int'(cen);
        end
        check("R4", seq, 4'b0010, "strobe pattern over four edges after fall");

        // R7: mode switches with a steady high pin cause no strobe
        sel = 3'b000;
        pin = 1'b1;
        repeat (6) tick();
        sel = 3'b111;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (cen) cnt++;
        end
        sel = 3'b110;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (cen) cnt++;
        end
        check("R7", cnt, 0, "strobes from switching pin modes with steady pin");

        // R7: stop and start take effect on the next clock
        sel = 3'b001;
        repeat (3) tick();
        sel = 3'b000;
        tick();
        check("R7", int'(cen), 0, "strobe one edge after switching to stop");
        sel = 3'b001;
        tick();
        check("R7", int'(cen), 1, "strobe one edge after switching to undivided");

        // R8: reset in mid-run
        rst = 1'b1;
        tick();
        check("R8", int'(cen), 0, "strobe after mid-run reset edge");
        rst = 1'b0;
        sel = 3'b000;
        pin = 1'b0;
        tick();

        // R8: reset clears the prescaler, so divide-by-8 starts a full period later
        rst = 1'b1;
        sel = 3'b010;
        tick();
        rst   = 1'b0;
        first = 0;
        for (int k = 1; k <= 20; k++) begin
            tick();
            if (cen && first == 0) first = k;
        end
        check("R8", first, 8, "first divide-by-8 strobe edge after reset");

        done = 1'b1;
        summary();
    end

endmodule